// File: doc/BRIEF.md
# Two-Channel Converter Frame Sequencer

This block is the host side of a serial link to a two-channel converter. It runs back-to-back 16-bit frames over a chip-select, serial-clock and data-in/data-out pin set. In each frame it sends a command word. The command picks the channel for the next conversion and keeps the converter in its normal mode. At the same time it shifts in the result word of the conversion that the previous command asked for.

The serial clock comes from the system clock. Its half period is set by a pin value, and the time chip select stays high between frames is set by a second pin value. Two plain pins choose the channel pattern: automatic alternation starting with channel 0, or a fixed channel.

Each received word is checked and decoded into a 12-bit sample and a channel tag. The sample leaves on a valid/ready stream. A payload, once valid, stays unchanged until the consumer takes it with ready high. While an undelivered sample is waiting, the next frame does not start, so no sample is ever lost or overwritten.

Top module: `adc_frame_seq`

## Requirements
- R1: Between frames the serial clock and chip select both idle high. A frame holds chip select low across exactly 16 falling and 16 rising serial-clock edges.
- R2: Each serial-clock low phase lasts `half_div`+1 system clocks.
- R3: Chip select stays high for at least `gap_cycles`+1 system clocks between frames.
- R4: The command goes out MSB first. Bits 15:14 are 0, bits 13 and 12 both carry the requested channel, and bits 11:0 are 0. Each bit changes right after a rising serial-clock edge, so the converter latches it on the following falling edge.
- R5: With `auto_alt`=1 the requested channel alternates 0,1,0,… from reset. With `auto_alt`=0 every frame requests `fixed_chan`.
- R6: The received bit is sampled at each rising edge, MSB first, giving a word w[15:0]. `m_data` is w[11:0] when RES_BITS=12, and w[11:2] zero-extended when RES_BITS=10. `m_chan` is w[13].
- R7: `m_err` is 1 if w[15:14]≠0, or if w[13]≠w[12], or (RES_BITS=10 only) if w[1:0]≠0.
- R8: `m_err` is also 1 if w[13] differs from the channel requested in the previous frame.
- R9: The result of the first frame after reset is not delivered. The first output carries the result of the second frame.
- R10: While `m_valid`=1 and `m_ready`=0, `m_valid` and the payload hold, and no new frame starts.
- R11: During reset, `cs_n`=1, `sclk`=1, `din`=0 and `m_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_alt | input | 1 | 1: alternate channels each frame; 0: fixed channel |
| fixed_chan | input | 1 | Channel requested when auto_alt is 0 |
| half_div | input | DIV_W | Serial clock half period minus one, in system clocks |
| gap_cycles | input | GAP_W | Minimum chip-select high time minus one |
| sclk | output | 1 | Serial clock to the converter |
| cs_n | output | 1 | Active-low frame select |
| din | output | 1 | Command bit to the converter |
| dout | input | 1 | Result bit from the converter |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Consumer accepts the sample |
| m_data | output | OUT_W | Decoded sample |
| m_chan | output | 1 | Channel tag received with the sample |
| m_err | output | 1 | Framing or channel-sequence error for this sample |

## Verification
The bench builds two instances with DIV_W=3 and GAP_W=3, one with RES_BITS=12 and one with RES_BITS=10. Both are fed by one behavioural converter model. The small counter widths let four configurations cover half periods of 1 to 4 clocks, gaps of 1 to 5 clocks, and both channel patterns within a few thousand cycles. On a repeating seven-frame pattern the model corrupts the leading bits, the mode bit or the channel tag, so every error cause and its clean counterpart are checked at both result widths.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int FRAME_BITS = 16;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  typedef enum logic [1:0] {ST_GAP, ST_LEAD, ST_LOW, ST_HIGH} seq_state_t;

  // command word: channel in bits 13 and 12 (equal pair keeps normal mode)
  function automatic logic [FRAME_BITS-1:0] make_cmd(input logic ch);
    logic [FRAME_BITS-1:0] w;
    w = '0;
    w[FRAME_BITS-3] = ch;
    w[FRAME_BITS-4] = ch;
    return w;
  endfunction
endpackage

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] tmr;

  assign tick = run && (tmr == half_div);

  always_ff @(posedge clk) begin
    if (!rst_n)            tmr <= '0;
    else if (!run || tick) tmr <= '0;
    else                   tmr <= tmr + 1'b1;
  end

  // R2: the phase counter never runs past the programmed half period
  p_tmr_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> tmr <= half_div);
endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift
  import adc_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] cmd,
  input  logic                  shift,
  input  logic                  dout_in,
  output logic                  din_out,
  output logic [FRAME_BITS-1:0] rx_word
);
  logic [FRAME_BITS-1:0] tx_sr;
  logic [FRAME_BITS-1:0] rx_sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sr <= '0;
      rx_sr <= '0;
    end else if (load) begin
      tx_sr <= cmd;
      rx_sr <= '0;
    end else if (shift) begin
      tx_sr <= {tx_sr[FRAME_BITS-2:0], 1'b0};
      rx_sr <= {rx_sr[FRAME_BITS-2:0], dout_in};
    end
  end

  assign din_out = tx_sr[FRAME_BITS-1];
  assign rx_word = rx_sr;
endmodule

// File: rtl/adc_word_check.sv
module adc_word_check
  import adc_seq_pkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int OUT_W    = 12
) (
  input  logic [FRAME_BITS-1:0] word_i,
  input  logic                  exp_ch,
  output logic [OUT_W-1:0]      sample_o,
  output logic                  chan_o,
  output logic                  err_o
);
  localparam int PAD = 12 - RES_BITS;
  logic trail_bad;

  generate
    if (PAD > 0) begin : g_trail
      assign trail_bad = |word_i[PAD-1:0];
    end else begin : g_no_trail
      assign trail_bad = 1'b0;
    end
  endgenerate

  assign sample_o = OUT_W'(word_i[11:PAD]);
  assign chan_o   = word_i[13];
  assign err_o    = (|word_i[15:14]) | (word_i[13] ^ word_i[12])
                  | (word_i[13] ^ exp_ch) | trail_bad;
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int OUT_W    = 12,
  parameter int DIV_W    = 4,
  parameter int GAP_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_alt,
  input  logic             fixed_chan,
  input  logic [DIV_W-1:0] half_div,
  input  logic [GAP_W-1:0] gap_cycles,
  output logic             sclk,
  output logic             cs_n,
  output logic             din,
  input  logic             dout,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [OUT_W-1:0] m_data,
  output logic             m_chan,
  output logic             m_err
);
  seq_state_t            state;
  logic [GAP_W-1:0]      gcnt;
  logic [CNT_W-1:0]      bcnt;
  logic                  cur_req, prev_req, started, primed;
  logic                  tick, start, rise, fin, nxt_ch;
  logic [FRAME_BITS-1:0] rx_word;
  logic [OUT_W-1:0]      dec_data;
  logic                  dec_chan, dec_err;

  assign nxt_ch = auto_alt ? ~cur_req : fixed_chan;
  assign start  = (state == ST_GAP) && (gcnt == gap_cycles) && !m_valid;
  assign rise   = (state == ST_LOW) && tick;
  assign fin    = (state == ST_HIGH) && tick && (bcnt == CNT_W'(FRAME_BITS));

  adc_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state != ST_GAP),
    .half_div(half_div), .tick(tick)
  );

  adc_frame_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(start), .cmd(make_cmd(nxt_ch)),
    .shift(rise), .dout_in(dout), .din_out(din), .rx_word(rx_word)
  );

  adc_word_check #(.RES_BITS(RES_BITS), .OUT_W(OUT_W)) u_check (
    .word_i(rx_word), .exp_ch(prev_req),
    .sample_o(dec_data), .chan_o(dec_chan), .err_o(dec_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_GAP;
      gcnt     <= '0;
      bcnt     <= '0;
      cs_n     <= 1'b1;
      sclk     <= 1'b1;
      cur_req  <= 1'b1;
      prev_req <= 1'b0;
      started  <= 1'b0;
      primed   <= 1'b0;
    end else begin
      unique case (state)
        ST_GAP: begin
          if (start) begin
            state    <= ST_LEAD;
            cs_n     <= 1'b0;
            bcnt     <= '0;
            prev_req <= cur_req;
            cur_req  <= nxt_ch;
            primed   <= started;
            started  <= 1'b1;
          end else if (gcnt < gap_cycles) begin
            gcnt <= gcnt + 1'b1;
          end
        end
        ST_LEAD: if (tick) begin
          state <= ST_LOW;
          sclk  <= 1'b0;
        end
        ST_LOW: if (tick) begin
          state <= ST_HIGH;
          sclk  <= 1'b1;
          bcnt  <= bcnt + 1'b1;
        end
        ST_HIGH: if (tick) begin
          if (fin) begin
            state <= ST_GAP;
            cs_n  <= 1'b1;
            gcnt  <= '0;
          end else begin
            state <= ST_LOW;
            sclk  <= 1'b0;
          end
        end
        default: state <= ST_GAP;
      endcase
    end
  end

  // output stage: loaded only when empty (frames start only with m_valid low)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_chan  <= 1'b0;
      m_err   <= 1'b0;
    end else if (fin && primed) begin
      m_valid <= 1'b1;
      m_data  <= dec_data;
      m_chan  <= dec_chan;
      m_err   <= dec_err;
    end else if (m_valid && m_ready) begin
      m_valid <= 1'b0;
    end
  end

  // R1: serial clock idles high whenever the frame select is inactive
  p_sclk_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);
  // R1: a frame closes only after sixteen rising edges
  p_frame_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $past(bcnt) == CNT_W'(FRAME_BITS));
  // R4: command bits 13 and 12 both carry the requested channel
  p_cmd_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && (bcnt == CNT_W'(2) || bcnt == CNT_W'(3))) |-> din == cur_req);
  // R10: a waiting sample holds its payload
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> m_valid && $stable(m_data) && $stable(m_chan) && $stable(m_err));
  // R10: no frame begins while a sample waits
  p_no_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !m_valid);
endmodule

// File: tb/adc_frame_seq_tb.sv
module adc_frame_seq_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, auto_alt, fixed_chan, m_ready, dout;
  logic [2:0] half_div, gap_cycles;
  logic       sclk, cs_n, din, m_valid, m_chan, m_err;
  logic [11:0] m_data;
  logic       sclk10, cs_n10, din10, m_valid10, m_chan10, m_err10;
  logic [11:0] m_data10;

  adc_frame_seq #(.RES_BITS(12), .OUT_W(12), .DIV_W(3), .GAP_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .auto_alt(auto_alt), .fixed_chan(fixed_chan),
    .half_div(half_div), .gap_cycles(gap_cycles), .sclk(sclk), .cs_n(cs_n),
    .din(din), .dout(dout), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_chan(m_chan), .m_err(m_err));

  adc_frame_seq #(.RES_BITS(10), .OUT_W(12), .DIV_W(3), .GAP_W(3)) u_dut10 (
    .clk(clk), .rst_n(rst_n), .auto_alt(auto_alt), .fixed_chan(fixed_chan),
    .half_div(half_div), .gap_cycles(gap_cycles), .sclk(sclk10), .cs_n(cs_n10),
    .din(din10), .dout(dout), .m_valid(m_valid10), .m_ready(m_ready),
    .m_data(m_data10), .m_chan(m_chan10), .m_err(m_err10));

  int checks = 0;
  int errors = 0;
  int cfg_id = 0;
  int frame_idx = 0;
  int dev_fall = 0;
  logic [15:0] dev_out, dev_cmd;
  logic dev_chan = 1'b0;
  logic frame_act = 1'b0;
  logic mirror_ok = 1'b1;
  logic [11:0] exp_dv [64];
  logic exp_ch [64];
  logic exp_e12 [64];
  logic exp_e10 [64];
  int   exp_inj [64];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic req_of(input int f);
    return auto_alt ? logic'(f % 2) : fixed_chan;
  endfunction

  // behavioural converter: first bit at select fall, later bits on falls 1..15
  always @(negedge cs_n) begin
    if (rst_n) begin : dev_start
      logic [11:0] dv;
      logic [1:0]  lead;
      logic        chb, modeb, e;
      logic [15:0] w;
      int          f, inj;
      f     = frame_idx;
      inj   = f % 7;
      dv    = 12'((f * 613 + cfg_id * 97 + 5) % 4096);
      lead  = (inj == 3) ? 2'b01 : 2'b00;
      chb   = (inj == 6) ? ~dev_chan : dev_chan;
      modeb = (inj == 5) ? ~chb : chb;
      w     = {lead, chb, modeb, dv};
      e     = (lead != 2'b00) || (chb != modeb) || (f > 0 && chb != req_of(f - 1));
      if (f < 64) begin
        exp_dv[f]  = dv;
        exp_ch[f]  = chb;
        exp_e12[f] = e;
        exp_e10[f] = e || (dv[1:0] != 2'b00);
        exp_inj[f] = inj;
      end
      dout      <= w[15];
      dev_out   <= {w[14:0], 1'b0};
      dev_fall  <= 0;
      frame_act <= 1'b1;
    end
  end

  always @(negedge sclk) begin
    if (rst_n && !cs_n) begin
      dev_cmd <= {dev_cmd[14:0], din};
      if (dev_fall >= 1) begin
        dout    <= dev_out[15];
        dev_out <= {dev_out[14:0], 1'b0};
      end
      dev_fall <= dev_fall + 1;
    end
  end

  always @(posedge cs_n) begin
    if (rst_n && frame_act) begin
      chk(dev_fall == 16, "R1", "falling edges per frame", dev_fall, 16);
      chk(dev_cmd[15:14] == 2'b00 && dev_cmd[11:0] == 12'h000 && dev_cmd[13] == dev_cmd[12],
          "R4", "command word layout", dev_cmd, {2'b00, dev_cmd[13], dev_cmd[13], 12'h000});
      chk(dev_cmd[13] == req_of(frame_idx), "R5", "requested channel",
          dev_cmd[13], req_of(frame_idx));
      chk(mirror_ok, "R6", "10-bit instance pin timing matches", mirror_ok, 1);
      mirror_ok = 1'b1;
      dev_chan  <= dev_cmd[13];
      frame_idx <= frame_idx + 1;
      frame_act <= 1'b0;
    end
  end

  // pin timing monitors
  int hi_cnt = 0;
  int lo_cnt = 0;
  logic last_cs = 1'b1;
  logic last_sclk = 1'b1;
  always @(negedge clk) begin
    if (!rst_n) begin
      hi_cnt = 0; lo_cnt = 0; last_cs = 1'b1; last_sclk = 1'b1;
    end else begin
      if (sclk10 !== sclk || cs_n10 !== cs_n || din10 !== din) mirror_ok = 1'b0;
      if (cs_n) hi_cnt++;
      else if (last_cs) begin
        chk(hi_cnt >= int'(gap_cycles) + 1, "R3", "select high time", hi_cnt, int'(gap_cycles) + 1);
        hi_cnt = 0;
      end
      if (!sclk) lo_cnt++;
      else if (!last_sclk) begin
        chk(lo_cnt == int'(half_div) + 1, "R2", "clock low time", lo_cnt, int'(half_div) + 1);
        lo_cnt = 0;
      end
      last_cs   = cs_n;
      last_sclk = sclk;
    end
  end

  task automatic run_cfg(input int id, input int hd, input int gp, input bit aa, input bit fc);
    int out_k, cyc, fi, f;
    bit stalled;
    logic [11:0] cap_d;
    logic cap_c, cap_e;
    string tag, tag10;
    rst_n = 1'b0;
    cfg_id = id; half_div = 3'(hd); gap_cycles = 3'(gp);
    auto_alt = aa; fixed_chan = fc; m_ready = 1'b0;
    frame_idx = 0; dev_chan = 1'b0; frame_act = 1'b0; dout = 1'b0; mirror_ok = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n && sclk && !din && !m_valid && !m_valid10, "R11", "reset pin state",
        {cs_n, sclk, din, m_valid}, 4'b1100);
    rst_n = 1'b1;
    out_k = 0; cyc = 0; stalled = 0;
    while (out_k < 14) begin
      @(negedge clk);
      cyc++;
      if (!stalled && out_k == 2 && m_valid) begin
        stalled = 1; m_ready = 1'b0;
        cap_d = m_data; cap_c = m_chan; cap_e = m_err; fi = frame_idx;
        repeat (150) @(negedge clk);
        chk(m_valid && m_data == cap_d && m_chan == cap_c && m_err == cap_e,
            "R10", "payload held under back-pressure", m_data, cap_d);
        chk(frame_idx == fi && cs_n, "R10", "no frame while output waits", frame_idx, fi);
      end
      m_ready = (cyc % 3) != 1;
      if (m_valid && m_ready) begin
        f = out_k + 1;
        tag   = (exp_inj[f] == 3 || exp_inj[f] == 5) ? "R7" : (exp_inj[f] == 6 ? "R8" : "R6");
        tag10 = (tag == "R6" && exp_dv[f][1:0] != 2'b00) ? "R7" : tag;
        chk(m_data == exp_dv[f], (out_k == 0) ? "R9" : "R6", "sample", m_data, exp_dv[f]);
        chk(m_chan == exp_ch[f], "R6", "channel tag", m_chan, exp_ch[f]);
        chk(m_err == exp_e12[f], tag, "error flag", m_err, exp_e12[f]);
        chk(m_valid10 && m_data10 == {2'b00, exp_dv[f][11:2]}, "R6", "10-bit sample",
            m_data10, {2'b00, exp_dv[f][11:2]});
        chk(m_chan10 == exp_ch[f], "R6", "10-bit channel tag", m_chan10, exp_ch[f]);
        chk(m_err10 == exp_e10[f], tag10, "10-bit error flag", m_err10, exp_e10[f]);
        out_k++;
      end
    end
    m_ready = 1'b0;
  endtask

  initial begin
    run_cfg(0, 0, 1, 1'b1, 1'b0);
    run_cfg(1, 1, 4, 1'b1, 1'b0);
    run_cfg(2, 3, 2, 1'b0, 1'b1);
    run_cfg(3, 2, 0, 1'b0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule